// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block drives one auxiliary-channel transaction to completion by repeating it until it succeeds or a retry budget is spent. On a start request it latches the transfer description (read or write, requested length, programmable defer delay) and issues attempts to a channel engine, one single-cycle issue pulse per attempt. The engine answers each attempt with a result class, a reply code and a received byte count. From these the controller decides whether to finish with success, finish with failure, retry at once, or retry after a wait.

Each failure class has its own counter and limit. A successful channel result clears the invalid-reply and timeout counters. An I2C defer clears the defer counter. Once any native or I2C-over-AUX defer has been seen, a later timeout is treated as a defer. Waits are counted in microseconds from an external one-cycle microsecond tick. When the transaction ends, the block raises a one-cycle done pulse together with a pass flag and the reply code of the last successful channel result.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset, att_go, busy, done and pass are low and final_reply is 4'hF (no reply seen).
- R2: att_go is a one-cycle pulse. It comes one cycle after a start is accepted in idle, one cycle after a retry-without-wait decision, and one cycle after the tick that ends a wait.
- R3: No more than MAX_ATT (7) attempts are issued. If the MAX_ATT-th attempt would retry, the transaction fails instead.
- R4: A result of success (att_result 0) with reply ACK (0) ends with pass. The exception is a read whose att_bytes is less than req_len: that counts as a short read, and the block waits ACK_WAIT_US ticks before retrying. Reaching ACK_LIM short reads fails.
- R5: Every success result clears the invalid-reply and timeout counters.
- R6: A native defer (reply 2) or an I2C-over-AUX defer (reply 4) sets a defer-seen flag that holds until the next start. It adds one to the defer counter and waits defer_dly ticks when defer_dly is nonzero. Reaching DEF_LIM fails.
- R7: An I2C-over-AUX NACK (reply 3) adds one to the defer counter, with no wait.
- R8: An I2C defer (reply 5) clears the defer counter and adds one to the I2C-defer counter. Reaching I2CD_LIM fails.
- R9: The following end the transaction with failure at once: a success result with AUX NACK (reply 1) or any reply code above 5; HPD disconnect (result 3); acquire failure (result 4); any result code above 4.
- R10: An invalid reply (result 1) adds one to the invalid counter and waits INV_WAIT_US ticks. Reaching INV_LIM (2) fails.
- R11: A timeout (result 2) is handled as a defer (R6 count, limit and wait) when the defer-seen flag is set. Otherwise it adds one to the timeout counter with no wait, and reaching TO_LIM (3) fails.
- R12: At the end, done is high for exactly one cycle with busy low. pass and final_reply hold until the next start. final_reply is the reply of the last success result, or 4'hF if there was none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| is_read | input | 1 | Transaction is a read |
| req_len | input | LEN_W | Requested byte count |
| defer_dly | input | DLY_W | Defer wait in microseconds |
| us_tick | input | 1 | One-cycle microsecond strobe |
| att_go | output | 1 | Issue one attempt |
| att_done | input | 1 | Attempt result valid |
| att_result | input | 3 | Result class: 0 ok, 1 invalid, 2 timeout, 3 HPD, 4 acquire |
| att_reply | input | 4 | Reply code: 0 ACK, 1 NACK, 2 defer, 3 I2C NACK, 4 I2C-over-AUX defer, 5 I2C defer |
| att_bytes | input | LEN_W | Bytes returned by the attempt |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end strobe |
| pass | output | 1 | Transaction succeeded |
| final_reply | output | 4 | Reply code of the last success result |

## Verification
The bench builds the block with DEF_LIM=3 and I2CD_LIM=4, so that the defer and I2C-defer limits fall well inside the 7-attempt cap. That makes a mixed sequence possible in which only the defer-counter clear allows success. It also allows a pattern that alternates I2C NACK and I2C defer and is stopped only by the attempt cap. ACK_WAIT_US=3 and INV_WAIT_US=4, with a 4-bit defer delay, keep every wait short enough to count tick by tick. The model therefore checks the exact cycle of each reissue after a wait.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

   localparam logic [2:0] RES_OK      = 3'd0;
   localparam logic [2:0] RES_INVALID = 3'd1;
   localparam logic [2:0] RES_TIMEOUT = 3'd2;

   localparam logic [3:0] RPL_ACK       = 4'd0;
   localparam logic [3:0] RPL_NACK      = 4'd1;
   localparam logic [3:0] RPL_DEFER     = 4'd2;
   localparam logic [3:0] RPL_I2C_NACK  = 4'd3;
   localparam logic [3:0] RPL_I2C_XDEF  = 4'd4;
   localparam logic [3:0] RPL_I2C_DEFER = 4'd5;
   localparam logic [3:0] RPL_NONE      = 4'hF;

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DELAY} st_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/aux_retry_wait.sv
module aux_retry_wait #(
   parameter int WAIT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   input  logic              us_tick,
   output logic              expire
);
   logic [WAIT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (load)                  cnt <= load_val;
      else if (us_tick && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expire = us_tick && (cnt == WAIT_W'(1));

   // R4: an idle counter stays idle until loaded
   a_r4_wait_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> (cnt == '0));

endmodule

// File: rtl/aux_retry_decide.sv
module aux_retry_decide
   import aux_retry_pkg::*;
#(
   parameter int LEN_W       = 5,
   parameter int DLY_W       = 8,
   parameter int CNT_W       = 3,
   parameter int ATT_W       = 3,
   parameter int WAIT_W      = 9,
   parameter int MAX_ATT     = 7,
   parameter int ACK_LIM     = 7,
   parameter int DEF_LIM     = 7,
   parameter int I2CD_LIM    = 7,
   parameter int INV_LIM     = 2,
   parameter int TO_LIM      = 3,
   parameter int ACK_WAIT_US = 300,
   parameter int INV_WAIT_US = 400
) (
   input  logic [2:0]        result,
   input  logic [3:0]        reply,
   input  logic [LEN_W-1:0]  bytes,
   input  logic              is_read,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DLY_W-1:0]  defer_dly,
   input  logic [ATT_W-1:0]  att_cnt,
   input  logic              sticky,
   input  logic [CNT_W-1:0]  ack_c, def_c, i2cd_c, inv_c, to_c,
   output logic [CNT_W-1:0]  ack_n, def_n, i2cd_n, inv_n, to_n,
   output logic              sticky_n,
   output logic              fin,
   output logic              ok,
   output logic [WAIT_W-1:0] wait_us
);
   localparam logic [CNT_W-1:0]  ACK_L  = CNT_W'(ACK_LIM);
   localparam logic [CNT_W-1:0]  DEF_L  = CNT_W'(DEF_LIM);
   localparam logic [CNT_W-1:0]  I2CD_L = CNT_W'(I2CD_LIM);
   localparam logic [CNT_W-1:0]  INV_L  = CNT_W'(INV_LIM);
   localparam logic [CNT_W-1:0]  TO_L   = CNT_W'(TO_LIM);
   localparam logic [ATT_W-1:0]  ATT_L  = ATT_W'(MAX_ATT);
   localparam logic [WAIT_W-1:0] ACK_WT = WAIT_W'(ACK_WAIT_US);
   localparam logic [WAIT_W-1:0] INV_WT = WAIT_W'(INV_WAIT_US);

   logic [WAIT_W-1:0] dly_w;
   assign dly_w = WAIT_W'(defer_dly);

   always_comb begin
      ack_n = ack_c;  def_n = def_c;  i2cd_n = i2cd_c;
      inv_n = inv_c;  to_n  = to_c;   sticky_n = sticky;
      fin = 1'b0;  ok = 1'b0;  wait_us = '0;
      case (result)
         RES_OK: begin
            inv_n = '0;
            to_n  = '0;
            case (reply)
               RPL_ACK: begin
                  if (is_read && (bytes < req_len)) begin
                     ack_n = ack_c + 1'b1;
                     if (ack_n >= ACK_L) fin = 1'b1;
                     else                wait_us = ACK_WT;
                  end else begin
                     fin = 1'b1;
                     ok  = 1'b1;
                  end
               end
               RPL_DEFER, RPL_I2C_XDEF: begin
                  sticky_n = 1'b1;
                  def_n    = def_c + 1'b1;
                  if (def_n >= DEF_L) fin = 1'b1;
                  else                wait_us = dly_w;
               end
               RPL_I2C_NACK: begin
                  def_n = def_c + 1'b1;
                  if (def_n >= DEF_L) fin = 1'b1;
               end
               RPL_I2C_DEFER: begin
                  def_n  = '0;
                  i2cd_n = i2cd_c + 1'b1;
                  if (i2cd_n >= I2CD_L) fin = 1'b1;
               end
               default: fin = 1'b1;
            endcase
         end
         RES_INVALID: begin
            inv_n = inv_c + 1'b1;
            if (inv_n >= INV_L) fin = 1'b1;
            else                wait_us = INV_WT;
         end
         RES_TIMEOUT: begin
            if (sticky) begin
               def_n = def_c + 1'b1;
               if (def_n >= DEF_L) fin = 1'b1;
               else                wait_us = dly_w;
            end else begin
               to_n = to_c + 1'b1;
               if (to_n >= TO_L) fin = 1'b1;
            end
         end
         default: fin = 1'b1;
      endcase
      if (!fin && (att_cnt >= ATT_L)) fin = 1'b1;
      if (fin) wait_us = '0;
   end

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
   import aux_retry_pkg::*;
#(
   parameter int LEN_W       = 5,
   parameter int DLY_W       = 8,
   parameter int MAX_ATT     = 7,
   parameter int ACK_LIM     = 7,
   parameter int DEF_LIM     = 7,
   parameter int I2CD_LIM    = 7,
   parameter int INV_LIM     = 2,
   parameter int TO_LIM      = 3,
   parameter int ACK_WAIT_US = 300,
   parameter int INV_WAIT_US = 400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_read,
   input  logic [LEN_W-1:0] req_len,
   input  logic [DLY_W-1:0] defer_dly,
   input  logic             us_tick,
   output logic             att_go,
   input  logic             att_done,
   input  logic [2:0]       att_result,
   input  logic [3:0]       att_reply,
   input  logic [LEN_W-1:0] att_bytes,
   output logic             busy,
   output logic             done,
   output logic             pass,
   output logic [3:0]       final_reply
);
   localparam int CNT_W  = $clog2(max3(max3(ACK_LIM, DEF_LIM, I2CD_LIM),
                                       max3(INV_LIM, TO_LIM, 1), 1) + 1);
   localparam int ATT_W  = $clog2(MAX_ATT + 1);
   localparam int WAIT_W = max3(DLY_W, $clog2(ACK_WAIT_US + 1),
                                $clog2(INV_WAIT_US + 1));
   localparam logic [ATT_W-1:0] ATT_L = ATT_W'(MAX_ATT);
   localparam logic [CNT_W-1:0] INV_L = CNT_W'(INV_LIM);

   if (MAX_ATT < 1 || ACK_LIM < 1 || DEF_LIM < 1 || I2CD_LIM < 1 ||
       INV_LIM < 1 || TO_LIM < 1) begin : g_bad_limit
      $error("aux_retry_ctrl: every limit must be at least 1");
   end
   if (ACK_WAIT_US < 1 || INV_WAIT_US < 1 || LEN_W < 1 || DLY_W < 1) begin : g_bad_width
      $error("aux_retry_ctrl: waits and widths must be at least 1");
   end

   st_e               state;
   logic              rd_q, sticky, done_q, pass_q;
   logic [LEN_W-1:0]  len_q;
   logic [DLY_W-1:0]  dly_q;
   logic [ATT_W-1:0]  att_cnt;
   logic [3:0]        reply_q;
   logic [CNT_W-1:0]  ack_c, def_c, i2cd_c, inv_c, to_c;
   logic [CNT_W-1:0]  ack_n, def_n, i2cd_n, inv_n, to_n;
   logic              sticky_n, fin, ok, expire, judge, load;
   logic [WAIT_W-1:0] wait_us;

   aux_retry_decide #(
      .LEN_W(LEN_W), .DLY_W(DLY_W), .CNT_W(CNT_W), .ATT_W(ATT_W),
      .WAIT_W(WAIT_W), .MAX_ATT(MAX_ATT), .ACK_LIM(ACK_LIM),
      .DEF_LIM(DEF_LIM), .I2CD_LIM(I2CD_LIM), .INV_LIM(INV_LIM),
      .TO_LIM(TO_LIM), .ACK_WAIT_US(ACK_WAIT_US), .INV_WAIT_US(INV_WAIT_US)
   ) u_decide (
      .result(att_result), .reply(att_reply), .bytes(att_bytes),
      .is_read(rd_q), .req_len(len_q), .defer_dly(dly_q),
      .att_cnt(att_cnt), .sticky(sticky),
      .ack_c(ack_c), .def_c(def_c), .i2cd_c(i2cd_c), .inv_c(inv_c), .to_c(to_c),
      .ack_n(ack_n), .def_n(def_n), .i2cd_n(i2cd_n), .inv_n(inv_n), .to_n(to_n),
      .sticky_n(sticky_n), .fin(fin), .ok(ok), .wait_us(wait_us)
   );

   assign judge = (state == ST_WAIT) && att_done;
   assign load  = judge && !fin && (wait_us != '0);

   aux_retry_wait #(.WAIT_W(WAIT_W)) u_wait (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wait_us),
      .us_tick(us_tick), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rd_q    <= 1'b0;
         len_q   <= '0;
         dly_q   <= '0;
         att_cnt <= '0;
         sticky  <= 1'b0;
         ack_c   <= '0; def_c <= '0; i2cd_c <= '0; inv_c <= '0; to_c <= '0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         reply_q <= RPL_NONE;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               rd_q    <= is_read;
               len_q   <= req_len;
               dly_q   <= defer_dly;
               att_cnt <= '0;
               sticky  <= 1'b0;
               ack_c   <= '0; def_c <= '0; i2cd_c <= '0; inv_c <= '0; to_c <= '0;
               pass_q  <= 1'b0;
               reply_q <= RPL_NONE;
               state   <= ST_ISSUE;
            end
            ST_ISSUE: begin
               att_cnt <= att_cnt + 1'b1;
               state   <= ST_WAIT;
            end
            ST_WAIT: if (att_done) begin
               ack_c  <= ack_n; def_c <= def_n; i2cd_c <= i2cd_n;
               inv_c  <= inv_n; to_c  <= to_n;  sticky <= sticky_n;
               if (att_result == RES_OK) reply_q <= att_reply;
               if (fin) begin
                  done_q <= 1'b1;
                  pass_q <= ok;
                  state  <= ST_IDLE;
               end else if (wait_us != '0) begin
                  state <= ST_DELAY;
               end else begin
                  state <= ST_ISSUE;
               end
            end
            ST_DELAY: if (expire) state <= ST_ISSUE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign att_go      = (state == ST_ISSUE);
   assign busy        = (state != ST_IDLE);
   assign done        = done_q;
   assign pass        = pass_q;
   assign final_reply = reply_q;

   // R2: one issue pulse per attempt
   a_r2_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      att_go |=> !att_go);
   // R3: never issue beyond the attempt cap
   a_r3_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      att_go |-> (att_cnt < ATT_L));
   // R12: done is a single-cycle strobe seen while idle
   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: an AUX NACK ends in failure on the next cycle
   a_r9_nack_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (judge && att_result == RES_OK && att_reply == RPL_NACK) |=> (done && !pass));
   // R5: a success result leaves invalid and timeout counters cleared
   a_r5_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (judge && att_result == RES_OK) |=> (to_c == '0 && inv_c == '0));
   // R6: the defer-seen flag holds through the transaction
   a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky && state != ST_IDLE) |=> sticky);
   // R10: invalid counter never passes its limit
   a_r10_inv_bound: assert property (@(posedge clk) disable iff (!rst_n)
      inv_c <= INV_L);

endmodule

// File: tb/aux_retry_ctrl_bench.sv
module aux_retry_ctrl_bench;
   localparam int LEN_W = 5, DLY_W = 4;
   localparam int B_ATT = 7, B_ACK = 7, B_DEF = 3, B_I2CD = 4, B_INV = 2, B_TO = 3;
   localparam int B_ACKW = 3, B_INVW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, is_read = 0, us_tick = 0, att_done = 0;
   logic [LEN_W-1:0] req_len = '0, att_bytes = '0;
   logic [DLY_W-1:0] defer_dly = '0;
   logic [2:0] att_result = '0;
   logic [3:0] att_reply = '0;
   logic att_go, busy, done, pass;
   logic [3:0] final_reply;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int q_res[16], q_rpl[16], q_byt[16], q_n;
   int m_ack, m_def, m_i2cd, m_inv, m_to, m_rd, m_len, m_dly, exp_reply;
   bit m_sticky;

   always #10 clk = ~clk;

   aux_retry_ctrl #(
      .LEN_W(LEN_W), .DLY_W(DLY_W), .MAX_ATT(B_ATT), .ACK_LIM(B_ACK),
      .DEF_LIM(B_DEF), .I2CD_LIM(B_I2CD), .INV_LIM(B_INV), .TO_LIM(B_TO),
      .ACK_WAIT_US(B_ACKW), .INV_WAIT_US(B_INVW)
   ) u_aux_retry_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
      .req_len(req_len), .defer_dly(defer_dly), .us_tick(us_tick),
      .att_go(att_go), .att_done(att_done), .att_result(att_result),
      .att_reply(att_reply), .att_bytes(att_bytes), .busy(busy),
      .done(done), .pass(pass), .final_reply(final_reply)
   );

   task automatic chk(input bit good, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cyc_chk(input string tag, input int e_go, input int e_busy, input int e_done);
      chk(att_go == e_go, tag, "att_go", att_go, e_go);
      chk(busy == e_busy, tag, "busy", busy, e_busy);
      chk(done == e_done, tag, "done", done, e_done);
   endtask

   task automatic add(input int r, input int p, input int b);
      q_res[q_n] = r; q_rpl[q_n] = p; q_byt[q_n] = b; q_n++;
   endtask

   // behavioural reference of the retry policy
   task automatic model_step(input int r, input int p, input int b,
                             output bit fin, output bit ok, output int w);
      fin = 0; ok = 0; w = 0;
      if (r == 0) begin
         m_inv = 0; m_to = 0; exp_reply = p;
         if (p == 0) begin
            if (m_rd != 0 && b < m_len) begin
               m_ack++; if (m_ack >= B_ACK) fin = 1; else w = B_ACKW;
            end else begin fin = 1; ok = 1; end
         end else if (p == 2 || p == 4) begin
            m_sticky = 1; m_def++;
            if (m_def >= B_DEF) fin = 1; else w = m_dly;
         end else if (p == 3) begin
            m_def++; if (m_def >= B_DEF) fin = 1;
         end else if (p == 5) begin
            m_def = 0; m_i2cd++; if (m_i2cd >= B_I2CD) fin = 1;
         end else fin = 1;
      end else if (r == 1) begin
         m_inv++; if (m_inv >= B_INV) fin = 1; else w = B_INVW;
      end else if (r == 2) begin
         if (m_sticky) begin m_def++; if (m_def >= B_DEF) fin = 1; else w = m_dly; end
         else begin m_to++; if (m_to >= B_TO) fin = 1; end
      end else fin = 1;
   endtask

   task automatic run_txn(input string tag, input int rd, input int len, input int dly,
                          input int e_pass, input int e_att);
      bit fin, ok, over;
      int w;
      m_ack = 0; m_def = 0; m_i2cd = 0; m_inv = 0; m_to = 0; m_sticky = 0;
      m_rd = rd; m_len = len; m_dly = dly; exp_reply = 15;
      over = 0;
      @(negedge clk);
      start = 1; is_read = rd[0]; req_len = LEN_W'(len); defer_dly = DLY_W'(dly);
      @(negedge clk);
      start = 0;
      for (int k = 0; k < 16 && !over; k++) begin
         cyc_chk({tag, " R2 issue"}, 1, 1, 0);
         @(negedge clk);
         for (int l = 0; l < k % 3; l++) begin
            cyc_chk({tag, " R2 hold"}, 0, 1, 0);
            @(negedge clk);
         end
         cyc_chk({tag, " R2 hold"}, 0, 1, 0);
         att_done = 1; att_result = 3'(q_res[k]); att_reply = 4'(q_rpl[k]);
         att_bytes = LEN_W'(q_byt[k]);
         model_step(q_res[k], q_rpl[k], q_byt[k], fin, ok, w);
         if (!fin && k + 1 >= B_ATT) begin fin = 1; ok = 0; end
         @(negedge clk);
         att_done = 0;
         if (fin) begin
            cyc_chk({tag, " R12 end"}, 0, 0, 1);
            chk(pass == ok, {tag, " R12"}, "pass vs model", pass, ok);
            chk(pass == e_pass, tag, "pass", pass, e_pass);
            chk(final_reply == 4'(exp_reply), {tag, " R12"}, "final_reply", final_reply, exp_reply);
            chk(k + 1 == e_att, {tag, " R3"}, "attempts", k + 1, e_att);
            @(negedge clk);
            cyc_chk({tag, " R12 pulse"}, 0, 0, 0);
            chk(pass == e_pass, {tag, " R12 hold"}, "pass", pass, e_pass);
            over = 1;
         end else if (w > 0) begin
            for (int t = 0; t < w; t++) begin
               cyc_chk({tag, " wait"}, 0, 1, 0);
               us_tick = 1;
               @(negedge clk);
               us_tick = 0;
               if (t < w - 1) begin
                  cyc_chk({tag, " wait"}, 0, 1, 0);
                  @(negedge clk);
               end
            end
         end
      end
      q_n = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      q_n = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(att_go == 0, "R1", "att_go", att_go, 0);
      chk(busy == 0, "R1", "busy", busy, 0);
      chk(done == 0, "R1", "done", done, 0);
      chk(pass == 0, "R1", "pass", pass, 0);
      chk(final_reply == 4'hF, "R1", "final_reply", final_reply, 15);
      rst_n = 1;
      @(negedge clk);

      add(0, 0, 0);                       run_txn("R4 write ack", 0, 4, 0, 1, 1);
      add(0, 0, 2); add(0, 0, 3); add(0, 0, 4);
                                          run_txn("R4 short reads", 1, 4, 0, 1, 3);
      for (int i = 0; i < 7; i++) add(0, 0, 1);
                                          run_txn("R4 ack limit", 1, 4, 0, 0, 7);
      add(0, 2, 0); add(0, 0, 0);         run_txn("R6 defer wait", 0, 2, 2, 1, 2);
      add(0, 2, 0); add(0, 4, 0); add(0, 2, 0);
                                          run_txn("R6 defer limit", 0, 2, 0, 0, 3);
      add(0, 4, 0); add(0, 3, 0); add(0, 5, 0); add(0, 4, 0); add(0, 3, 0); add(0, 0, 0);
                                          run_txn("R8 defer clear", 0, 1, 1, 1, 6);
      add(0, 3, 0); add(0, 3, 0); add(0, 3, 0);
                                          run_txn("R7 i2c nack", 0, 1, 5, 0, 3);
      for (int i = 0; i < 4; i++) add(0, 5, 0);
                                          run_txn("R8 i2c defer limit", 0, 1, 0, 0, 4);
      add(0, 3, 0); add(0, 5, 0); add(0, 3, 0); add(0, 5, 0); add(0, 3, 0); add(0, 5, 0); add(0, 3, 0);
                                          run_txn("R3 attempt cap", 0, 1, 0, 0, 7);
      add(0, 1, 0);                       run_txn("R9 aux nack", 0, 1, 0, 0, 1);
      add(3, 0, 0);                       run_txn("R9 hpd", 0, 1, 0, 0, 1);
      add(1, 0, 0); add(4, 0, 0);         run_txn("R9 acquire", 0, 1, 0, 0, 2);
      add(0, 9, 0);                       run_txn("R9 unknown reply", 0, 1, 0, 0, 1);
      add(6, 0, 0);                       run_txn("R9 unknown result", 0, 1, 0, 0, 1);
      add(1, 0, 0); add(1, 0, 0);         run_txn("R10 invalid limit", 0, 1, 0, 0, 2);
      add(1, 0, 0); add(0, 0, 0);         run_txn("R10 invalid retry", 0, 1, 0, 1, 2);
      add(2, 0, 0); add(2, 0, 0); add(2, 0, 0);
                                          run_txn("R11 timeout limit", 0, 1, 0, 0, 3);
      add(2, 0, 0); add(2, 0, 0); add(0, 0, 1); add(2, 0, 0); add(2, 0, 0); add(0, 0, 3);
                                          run_txn("R5 ok clears", 1, 3, 0, 1, 6);
      add(0, 2, 0); add(2, 0, 0); add(0, 0, 0);
                                          run_txn("R11 timeout as defer", 0, 1, 2, 1, 3);
      add(0, 4, 0); add(2, 0, 0); add(2, 0, 0);
                                          run_txn("R11 sticky limit", 0, 1, 0, 0, 3);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule